// File: doc/BRIEF.md
# Acquisition Event Status and Control Register Pair

This block is the event and interrupt front end of a data-acquisition card. A byte-wide bus reaches two registers. The status register returns live sample-buffer flags together with three sticky event latches: conversion done, external trigger seen and external interrupt seen. Writing ones to the low three bits of that register clears the matching latches. The control register holds the conversion trigger source, a burst enable, an enable for the external interrupt, a three-bit interrupt line code and a master interrupt enable.

The status address also guards a small extended configuration latch. This latch holds a clock-rate select, an armed flag and a post-trigger flag. It loads only through a fixed three-write unlock sequence on the status address. Any other write leaves it unchanged. A single interrupt output combines the latches with the enables. A line-number output turns the control register's line code back into the system interrupt number it stands for.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the three event latches, the control register and the extended latch read zero, and `irq_out` is low.
- R2: A read at address 0 returns {clock select, gate input, external-trigger latch, conversion latch, external-interrupt latch, buffer full, buffer half, buffer not empty} from bit 7 down to bit 0. Bits 0, 1, 2 and 6 follow their inputs in the same cycle.
- R3: A one-cycle pulse on `evt_conv`, `evt_xtrig` or `evt_xint` sets its latch (status bits 4, 5 and 3) on the next clock edge. The latch then stays set until it is cleared.
- R4: In a write to address 0, data bit 0 clears the conversion latch, bit 1 clears the external-trigger latch and bit 2 clears the external-interrupt latch. Several may be cleared in one write, and zero bits leave their latches unchanged.
- R5: When an event pulse and a clear of the same latch fall in the same cycle, the latch ends up set.
- R6: Three consecutive writes to address 0 load the extended latch from data bits 7:5 of the third write: first 0x10, then a byte with bit 4 set, then a byte with bit 4 clear. Bit 7 drives `clk_fast_sel` and status bit 7, bit 6 drives `post_mode` and bit 5 drives `armed`.
- R7: A write to address 0 that does not complete the R6 sequence never changes the extended latch. This covers a lone value write, a sequence broken by a write without bit 4, and a sequence whose first write is not exactly 0x10. Writes to address 1 neither advance nor break the sequence.
- R8: A write to address 1 loads the control register, and a read at address 1 returns it. Bits 1:0 drive `trig_src`, bit 2 drives `burst_en`, bit 3 enables the external interrupt, bits 6:4 are the line code and bit 7 is the master interrupt enable.
- R9: `irq_out` is high exactly when the master enable is set and either the conversion latch is set or both the external-interrupt latch and its enable are set. The external-trigger latch never raises it.
- R10: `irq_line` shows the system interrupt number for the line code: code 4 gives 10, code 1 gives 11, code 6 gives 15, codes 2, 3, 5 and 7 give their own value, and code 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 status, 1 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| fifo_nempty | input | 1 | Sample buffer holds data |
| fifo_half | input | 1 | Sample buffer at least half full |
| fifo_full | input | 1 | Sample buffer full |
| gate_in | input | 1 | Digital gate input level |
| evt_conv | input | 1 | Conversion-done event pulse |
| evt_xtrig | input | 1 | External trigger event pulse |
| evt_xint | input | 1 | External interrupt event pulse |
| irq_out | output | 1 | Qualified interrupt request |
| trig_src | output | 2 | Conversion trigger source |
| burst_en | output | 1 | Burst mode enable |
| irq_line | output | 4 | System interrupt number decoded from the line code |
| armed | output | 1 | Extended latch: armed flag |
| post_mode | output | 1 | Extended latch: post-trigger mode |
| clk_fast_sel | output | 1 | Extended latch: fast clock select |

## Verification
The assertions take three things for granted. A write lasts exactly one cycle, so each strobe counts as one step of the unlock sequence. Event inputs are synchronous pulses that meet setup to the clock. Reset is held for at least one edge before any check applies. The bench keeps to these rules: it raises `bus_wr` for a single cycle inside a task and drives every event pulse on a falling edge for one full cycle. The set-versus-clear collisions are built on purpose by sharing that single cycle between a pulse and a clearing write.

// File: rtl/acq_irq_pkg.sv
// Package: shared constants and the unlock state type for the event/control register pair.
// Assumes a byte-wide bus; bit positions below are the ones software decodes.
package acq_irq_pkg;
    localparam int BYTE_W     = 8;
    localparam int N_EVT      = 3;          // conv, xtrig, xint (clear-bit order)
    localparam int EVT_CONV   = 0;
    localparam int EVT_XTRIG  = 1;
    localparam int EVT_XINT   = 2;
    localparam int EXT_KEY    = 4;          // bit that marks an unlock write
    localparam int EXT_LSB    = 5;          // extended field occupies [7:5]
    localparam int EXT_W      = BYTE_W - EXT_LSB;
    localparam logic [BYTE_W-1:0] KEY_BYTE = 8'h10;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_KEY  = 2'd1,
        UL_LOAD = 2'd2
    } unlock_t;
endpackage

// File: rtl/acq_evt_latch.sv
// Module: bank of sticky event latches with write-1-to-clear.
// Assumes set and clear are synchronous single-cycle strobes; set has priority.
module acq_evt_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] lat_o
);
    for (genvar g = 0; g < N; g++) begin : g_lat
        // Hold, clear or set one latch; a set in the clearing cycle wins.
        always_ff @(posedge clk) begin
            if (!rst_n)          lat_o[g] <= 1'b0;
            else if (set_i[g])   lat_o[g] <= 1'b1;
            else if (clr_i[g])   lat_o[g] <= 1'b0;
        end

        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> lat_o[g]);
        a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !lat_o[g]);
        a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_o[g] && !clr_i[g]) |=> lat_o[g]);
    end
endmodule

// File: rtl/acq_ext_unlock.sv
// Module: three-write unlock sequencer guarding the extended configuration latch.
// Assumes wr_i is high for exactly one cycle per bus write to the status address.
module acq_ext_unlock
    import acq_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [EXT_W-1:0]  ext_o
);
    unlock_t st;
    logic    load_now;

    // A load happens only on a key-free write after the second step.
    assign load_now = wr_i && (st == UL_LOAD) && !wdata_i[EXT_KEY];

    // Advance the sequence on each status write; any stray write restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= UL_IDLE;
        end else if (wr_i) begin
            unique case (st)
                UL_IDLE: st <= (wdata_i == KEY_BYTE) ? UL_KEY : UL_IDLE;
                UL_KEY:  st <= wdata_i[EXT_KEY] ? UL_LOAD : UL_IDLE;
                UL_LOAD: st <= (wdata_i == KEY_BYTE) ? UL_KEY : UL_IDLE;
                default: st <= UL_IDLE;
            endcase
        end
    end

    // Capture the extended field on the closing write of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_o <= '0;
        else if (load_now) ext_o <= wdata_i[BYTE_W-1:EXT_LSB];
    end

    a_r7_ext_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && st == UL_LOAD && !wdata_i[EXT_KEY]) |=> $stable(ext_o));
    a_r6_ext_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && st == UL_LOAD && !wdata_i[EXT_KEY])
        |=> ext_o == $past(wdata_i[BYTE_W-1:EXT_LSB]));
endmodule

// File: rtl/acq_line_map.sv
// Module: decodes the 3-bit interrupt line code into the system line number.
// Assumes code 0 means no line; purely combinational.
module acq_line_map (
    input  logic [2:0] code_i,
    output logic [3:0] line_o
);
    // Remap the three codes that stand for high lines; others pass through.
    always_comb begin
        unique case (code_i)
            3'd4:    line_o = 4'd10;
            3'd1:    line_o = 4'd11;
            3'd6:    line_o = 4'd15;
            default: line_o = {1'b0, code_i};
        endcase
    end
endmodule

// File: rtl/acq_irq_ctrl.sv
// Module: status/control register pair with sticky events, unlockable extended
// latch and a qualified interrupt. Assumes one-cycle bus writes and event pulses.
module acq_irq_ctrl
    import acq_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              fifo_nempty,
    input  logic              fifo_half,
    input  logic              fifo_full,
    input  logic              gate_in,
    input  logic              evt_conv,
    input  logic              evt_xtrig,
    input  logic              evt_xint,
    output logic              irq_out,
    output logic [1:0]        trig_src,
    output logic              burst_en,
    output logic [3:0]        irq_line,
    output logic              armed,
    output logic              post_mode,
    output logic              clk_fast_sel
);
    logic              wr_stat, wr_ctrl;
    logic [N_EVT-1:0]  evt_set, evt_clr, evt_lat;
    logic [EXT_W-1:0]  ext_q;
    logic [BYTE_W-1:0] ctrl_q, stat_byte;
    logic              xint_en, int_en;

    assign wr_stat = bus_wr && !bus_addr;
    assign wr_ctrl = bus_wr && bus_addr;

    assign evt_set[EVT_CONV]  = evt_conv;
    assign evt_set[EVT_XTRIG] = evt_xtrig;
    assign evt_set[EVT_XINT]  = evt_xint;
    assign evt_clr = wr_stat ? bus_wdata[N_EVT-1:0] : '0;

    acq_evt_latch #(.N(N_EVT)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (evt_clr),
        .lat_o (evt_lat)
    );

    acq_ext_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_stat),
        .wdata_i (bus_wdata),
        .ext_o   (ext_q)
    );

    // Load the control register on writes to address 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    acq_line_map u_map (
        .code_i (ctrl_q[6:4]),
        .line_o (irq_line)
    );

    assign trig_src     = ctrl_q[1:0];
    assign burst_en     = ctrl_q[2];
    assign xint_en      = ctrl_q[3];
    assign int_en       = ctrl_q[7];
    assign armed        = ext_q[0];
    assign post_mode    = ext_q[1];
    assign clk_fast_sel = ext_q[2];

    // Assemble the status byte from live flags and latches.
    always_comb begin
        stat_byte = {clk_fast_sel, gate_in, evt_lat[EVT_XTRIG], evt_lat[EVT_CONV],
                     evt_lat[EVT_XINT], fifo_full, fifo_half, fifo_nempty};
    end

    assign bus_rdata = bus_addr ? ctrl_q : stat_byte;
    assign irq_out   = int_en && (evt_lat[EVT_CONV] || (xint_en && evt_lat[EVT_XINT]));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ctrl_q[7] && (evt_lat[EVT_CONV] || evt_lat[EVT_XINT])));
    a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));
    a_r8_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ctrl_q == $past(bus_wdata));
endmodule

// File: tb/acq_irq_ctrl_tb.sv
module acq_irq_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       fifo_nempty = 0, fifo_half = 0, fifo_full = 0, gate_in = 0;
    logic       evt_conv = 0, evt_xtrig = 0, evt_xint = 0;
    logic       irq_out, burst_en, armed, post_mode, clk_fast_sel;
    logic [1:0] trig_src;
    logic [3:0] irq_line;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_nempty(fifo_nempty), .fifo_half(fifo_half), .fifo_full(fifo_full),
        .gate_in(gate_in), .evt_conv(evt_conv), .evt_xtrig(evt_xtrig),
        .evt_xint(evt_xint), .irq_out(irq_out), .trig_src(trig_src),
        .burst_en(burst_en), .irq_line(irq_line), .armed(armed),
        .post_mode(post_mode), .clk_fast_sel(clk_fast_sel)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
        @(negedge clk); bus_wr = 0; bus_wdata = 0; bus_addr = 0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = 0;
    endtask

    task automatic pulse(logic c, logic t, logic x);
        @(negedge clk); evt_conv = c; evt_xtrig = t; evt_xint = x;
        @(negedge clk); evt_conv = 0; evt_xtrig = 0; evt_xint = 0;
    endtask

    task automatic unlock(logic [7:0] v);
        wr(0, 8'h10); wr(0, 8'h10 | v); wr(0, v);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(0, d); check("R1 status", d, 8'h00);
        rd(1, d); check("R1 ctrl", d, 8'h00);
        check("R1 irq", {7'b0, irq_out}, 8'h00);
    endtask

    task automatic t_live();
        logic [7:0] d;
        @(negedge clk); fifo_nempty = 1; fifo_full = 1; gate_in = 1;
        rd(0, d); check("R2 live a", d, 8'h45);
        fifo_nempty = 0; fifo_full = 0; fifo_half = 1; gate_in = 0;
        rd(0, d); check("R2 live b", d, 8'h02);
        fifo_half = 0;
    endtask

    task automatic t_latch_clear();
        logic [7:0] d;
        pulse(1, 0, 0); rd(0, d); check("R3 conv", d, 8'h10);
        pulse(0, 1, 0); rd(0, d); check("R3 xtrig", d, 8'h30);
        pulse(0, 0, 1); repeat (3) @(negedge clk);
        rd(0, d); check("R3 hold", d, 8'h38);
        wr(0, 8'h02); rd(0, d); check("R4 clr xtrig", d, 8'h18);
        wr(0, 8'h05); rd(0, d); check("R4 clr both", d, 8'h00);
        pulse(1, 1, 1); wr(0, 8'h07); rd(0, d); check("R4 clr all", d, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        @(negedge clk); evt_conv = 1; evt_xint = 1;
        bus_addr = 0; bus_wr = 1; bus_wdata = 8'h05;
        @(negedge clk); evt_conv = 0; evt_xint = 0; bus_wr = 0; bus_wdata = 0;
        rd(0, d); check("R5 set wins", d, 8'h18);
        wr(0, 8'h07);
    endtask

    task automatic t_ext();
        logic [7:0] d;
        unlock(8'hA0); rd(0, d); check("R6 load A0 status", d, 8'h80);
        check("R6 outs", {5'b0, clk_fast_sel, post_mode, armed}, 8'h05);
        unlock(8'h60);
        check("R6 load 60", {5'b0, clk_fast_sel, post_mode, armed}, 8'h03);
        wr(0, 8'hE0);
        check("R7 lone write", {5'b0, clk_fast_sel, post_mode, armed}, 8'h03);
        wr(0, 8'h10); wr(0, 8'h80); wr(0, 8'h80);
        check("R7 broken seq", {5'b0, clk_fast_sel, post_mode, armed}, 8'h03);
        wr(0, 8'h30); wr(0, 8'h90); wr(0, 8'h80);
        check("R7 bad key", {5'b0, clk_fast_sel, post_mode, armed}, 8'h03);
        wr(0, 8'h10); wr(1, 8'h00); wr(0, 8'h90); wr(1, 8'h00); wr(0, 8'h80);
        check("R7 ctrl interleave", {5'b0, clk_fast_sel, post_mode, armed}, 8'h04);
    endtask

    task automatic t_ctrl_irq();
        logic [7:0] d;
        wr(1, 8'h47); rd(1, d); check("R8 readback", d, 8'h47);
        check("R8 fields", {5'b0, burst_en, trig_src}, 8'h07);
        check("R10 code4", {4'b0, irq_line}, 8'd10);
        pulse(1, 0, 0);
        check("R9 no enable", {7'b0, irq_out}, 8'h00);
        wr(1, 8'h80); check("R9 conv irq", {7'b0, irq_out}, 8'h01);
        wr(0, 8'h01); pulse(0, 1, 1);
        check("R9 xint off, xtrig", {7'b0, irq_out}, 8'h00);
        wr(1, 8'h88); check("R9 xint on", {7'b0, irq_out}, 8'h01);
        wr(0, 8'h04); check("R9 cleared", {7'b0, irq_out}, 8'h00);
        wr(1, 8'h10); check("R10 code1", {4'b0, irq_line}, 8'd11);
        wr(1, 8'h60); check("R10 code6", {4'b0, irq_line}, 8'd15);
        wr(1, 8'h50); check("R10 code5", {4'b0, irq_line}, 8'd5);
        wr(1, 8'h00); check("R10 code0", {4'b0, irq_line}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_live();
        t_latch_clear();
        t_set_wins();
        t_ext();
        t_ctrl_irq();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule